// File: doc/BRIEF.md
# Input Capture Unit with Agreement Filter

This block timestamps an external event. A two-flop synchroniser brings the raw capture pin into the clock domain. An optional agreement filter can follow it. The filtered level then feeds an edge detector. When the selected edge arrives, the block copies the running counter value into the capture register. It also raises a capture flag, and an interrupt request follows the flag when both enables are set. The counter lives outside the block and arrives on an input.

When the timer mode uses the capture register as its TOP value, the `cap_is_top` input is high. In that case the pin is ignored, and software may load the capture register directly. The flag then marks the counter reaching TOP, which is signalled by the `cnt_at_top` input.

The filter is a two-state machine with a run counter. In state FLT_LO the filtered level is low and in FLT_HI it is high. The transition FLT_LO→FLT_HI, or FLT_HI→FLT_LO, fires when the fourth consecutive sample differs from the current state. Any agreeing sample resets the run count. While the filter is disabled the state simply follows the synchronised sample.

The flag is a second two-state machine. FLG_IDLE→FLG_PEND fires on a set event. FLG_PEND→FLG_IDLE fires on a clear event when no set event occurs in the same cycle.

Top module: `icu_top`

## Requirements
- R1: After reset, `cap_val` is 0, `cap_flag` is 0 and `irq` is 0, and the internal sample history reads as low.
- R2: With `filt_en`=0 and `cap_is_top`=0, a qualifying pin transition first sampled at clock edge e0 loads `cap_val` with the `cnt_val` present at edge e0+2, and sets `cap_flag` at that same edge.
- R3: With `filt_en`=1, the filtered level changes only after 4 consecutive synchronised samples differ from it. A capture therefore lands at edge e0+6, and a pin pulse shorter than 4 cycles causes no capture.
- R4: With `edge_rise`=1 only a low-to-high transition triggers a capture. With `edge_rise`=0 only a high-to-low transition does.
- R5: Changing `edge_rise` while the pin is steady causes no capture and does not set the flag.
- R6: While `cap_is_top`=1, pin transitions leave `cap_val` and `cap_flag` unchanged, and a high `cnt_at_top` sets `cap_flag` at the next edge.
- R7: While `cap_is_top`=1, a high `cap_wr` loads `cap_wdata` into `cap_val` at the next edge. While `cap_is_top`=0, `cap_wr` is ignored.
- R8: `flag_clr`=1 or `irq_ack`=1 clears `cap_flag` at the next edge. A set event in the same cycle wins, and the flag stays set.
- R9: `irq` is high exactly when `cap_flag`, `int_en` and `glob_ie` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Raw, asynchronous capture pin |
| cnt_val | input | CNT_W | Running counter value |
| cnt_at_top | input | 1 | Counter has reached TOP this cycle |
| cap_is_top | input | 1 | Capture register serves as TOP |
| filt_en | input | 1 | Enable the 4-sample agreement filter |
| edge_rise | input | 1 | 1 = rising edge triggers, 0 = falling edge triggers |
| int_en | input | 1 | Capture interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_ack | input | 1 | Interrupt acknowledge for the capture vector |
| cap_wr | input | 1 | Software write strobe for the capture register |
| cap_wdata | input | CNT_W | Software write data |
| cap_val | output | CNT_W | Capture register |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Capture interrupt request |

## Verification
Single clean edges of both polarities, with the filter off and then on, tell the 2-cycle path apart from the 6-cycle path. They also show that the wrong polarity is rejected. A 3-cycle glitch against a long pulse separates a filter that counts agreement from one that merely delays. Toggling the edge select on a steady pin exposes spurious triggers from history handling. Top-mode phases with pin activity, TOP pulses and software writes, followed by a long random mix of every input, exercise the flag priority and the mode switch against the reference model on every clock.

// File: rtl/icu_pkg.sv
package icu_pkg;
    typedef enum logic {FLT_LO = 1'b0, FLT_HI = 1'b1} flt_state_e;
    typedef enum logic {FLG_IDLE = 1'b0, FLG_PEND = 1'b1} flg_state_e;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q[0] <= din;
            for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
        end
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/icu_filter.sv
module icu_filter
    import icu_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_en,
    input  logic din,
    output logic dout
);
    localparam int RW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [RW-1:0] LAST = RW'(FILT_LEN - 1);

    flt_state_e     st_q, st_d;
    logic [RW-1:0]  run_q, run_d;
    logic           differ;

    always_comb begin
        st_d   = st_q;
        run_d  = '0;
        differ = 1'b0;
        unique case (st_q)
            FLT_LO:  differ = din;
            FLT_HI:  differ = !din;
            default: differ = 1'b0;
        endcase
        if (!filt_en) begin
            st_d = din ? FLT_HI : FLT_LO;
        end else if (differ) begin
            if (run_q == LAST) st_d = din ? FLT_HI : FLT_LO;
            else               run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLT_LO;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    assign dout = filt_en ? (st_q == FLT_HI) : din;

    AST_FILT_HOLDS_SHORT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && run_q != LAST) |=> $stable(st_q)); // R3
endmodule

// File: rtl/icu_edge.sv
module icu_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_sel,
    output logic trig
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign trig = (lvl != prev_q) && (lvl == rise_sel);

    AST_TRIG_NEEDS_LEVEL_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> (lvl != $past(lvl))); // R5
endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_at_top,
    input  logic             cap_is_top,
    input  logic             filt_en,
    input  logic             edge_rise,
    input  logic             int_en,
    input  logic             glob_ie,
    input  logic             flag_clr,
    input  logic             irq_ack,
    input  logic             cap_wr,
    input  logic [CNT_W-1:0] cap_wdata,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             irq
);
    logic sync_s, filt_s, trig;
    logic pin_cap, set_evt, clr_evt;
    logic [CNT_W-1:0] cap_q;
    flg_state_e flg_q, flg_d;

    icu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cap_pin), .dout(sync_s));

    icu_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .din(sync_s), .dout(filt_s));

    icu_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(filt_s), .rise_sel(edge_rise), .trig(trig));

    assign pin_cap = trig && !cap_is_top;
    assign set_evt = cap_is_top ? cnt_at_top : trig;
    assign clr_evt = flag_clr || irq_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cap_q <= '0;
        else if (pin_cap)              cap_q <= cnt_val;
        else if (cap_is_top && cap_wr) cap_q <= cap_wdata;
    end

    always_comb begin
        flg_d = flg_q;
        unique case (flg_q)
            FLG_IDLE: if (set_evt)             flg_d = FLG_PEND;
            FLG_PEND: if (clr_evt && !set_evt) flg_d = FLG_IDLE;
            default:                           flg_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= FLG_IDLE;
        else        flg_q <= flg_d;
    end

    always_comb begin
        cap_val  = cap_q;
        cap_flag = (flg_q == FLG_PEND);
        irq      = cap_flag && int_en && glob_ie;
    end

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        pin_cap |=> (cap_q == $past(cnt_val))); // R2
    AST_EDGE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> (filt_s == edge_rise && filt_s != $past(filt_s))); // R4
    AST_TOP_IGNORES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_is_top && !cap_wr) |=> $stable(cap_q)); // R6
    AST_SW_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_is_top && cap_wr) |=> (cap_q == $past(cap_wdata))); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> cap_flag); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !cap_flag); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cap_flag); // R9
endmodule

// File: tb/icu_top_bench.sv
module icu_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0, cnt_at_top = 1'b0, cap_is_top = 1'b0;
    logic        filt_en = 1'b0, edge_rise = 1'b1, int_en = 1'b0, glob_ie = 1'b0;
    logic        flag_clr = 1'b0, irq_ack = 1'b0, cap_wr = 1'b0;
    logic [15:0] cnt_val = 16'd0, cap_wdata = 16'd0;
    logic [15:0] cap_val;
    logic        cap_flag, irq;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    bit m_s1, m_s2, m_lvl, m_prev, m_flag, m_fo, m_tr, m_st;
    int m_run;
    logic [15:0] m_cap;

    always #2 clk = ~clk; // 250 MHz

    icu_top u_icu_top (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .cnt_val(cnt_val),
        .cnt_at_top(cnt_at_top), .cap_is_top(cap_is_top), .filt_en(filt_en),
        .edge_rise(edge_rise), .int_en(int_en), .glob_ie(glob_ie),
        .flag_clr(flag_clr), .irq_ack(irq_ack), .cap_wr(cap_wr),
        .cap_wdata(cap_wdata), .cap_val(cap_val), .cap_flag(cap_flag), .irq(irq));

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_lvl = 0; m_prev = 0; m_flag = 0; m_run = 0; m_cap = 16'd0;
        end else begin
            m_fo = filt_en ? m_lvl : m_s2;
            m_tr = (m_fo != m_prev) && (m_fo == edge_rise) && !cap_is_top;
            m_st = cap_is_top ? cnt_at_top : m_tr;
            if (!filt_en) begin
                m_lvl = m_s2; m_run = 0;
            end else if (m_s2 != m_lvl) begin
                m_run++;
                if (m_run == 4) begin m_lvl = m_s2; m_run = 0; end
            end else m_run = 0;
            m_prev = m_fo;
            m_s2 = m_s1;
            m_s1 = cap_pin;
            if (m_tr) m_cap = cnt_val;
            else if (cap_is_top && cap_wr) m_cap = cap_wdata;
            if (m_st) m_flag = 1;
            else if (flag_clr || irq_ack) m_flag = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(cap_val == m_cap, "R2 cap_val vs model", int'(cap_val), int'(m_cap));
        chk(cap_flag == m_flag, "R8 cap_flag vs model", int'(cap_flag), int'(m_flag));
        chk(irq == (m_flag & int_en & glob_ie), "R9 irq vs model", int'(irq),
            int'(m_flag & int_en & glob_ie));
        cnt_val = cnt_val + 16'd1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        int c;
        logic [15:0] v;
        repeat (3) step();
        chk(cap_val == 16'd0, "R1 reset cap_val", int'(cap_val), 0);
        chk(cap_flag == 1'b0, "R1 reset flag", int'(cap_flag), 0);
        chk(irq == 1'b0, "R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        int_en = 1; glob_ie = 1; edge_rise = 1;
        repeat (3) step();

        // R2 rising edge, no filter
        c = int'(cnt_val); cap_pin = 1;
        repeat (4) step();
        chk(cap_val == 16'(c + 2), "R2 capture latency", int'(cap_val), c + 2);
        chk(cap_flag == 1'b1, "R2 flag set", int'(cap_flag), 1);
        chk(irq == 1'b1, "R9 irq high", int'(irq), 1);
        flag_clr = 1; step(); flag_clr = 0; step();
        chk(cap_flag == 1'b0, "R8 write-one clear", int'(cap_flag), 0);

        // R4 falling ignored when rising selected
        v = cap_val; cap_pin = 0; repeat (5) step();
        chk(cap_flag == 1'b0, "R4 wrong polarity flag", int'(cap_flag), 0);
        chk(cap_val == v, "R4 wrong polarity cap", int'(cap_val), int'(v));

        // R5 select toggles on steady pin
        edge_rise = 0; repeat (3) step();
        edge_rise = 1; repeat (3) step();
        edge_rise = 0; repeat (3) step();
        chk(cap_flag == 1'b0, "R5 select change no capture", int'(cap_flag), 0);

        cap_pin = 1; repeat (5) step();
        chk(cap_flag == 1'b0, "R4 rising ignored in falling mode", int'(cap_flag), 0);
        c = int'(cnt_val); cap_pin = 0; repeat (4) step();
        chk(cap_val == 16'(c + 2), "R4 falling capture", int'(cap_val), c + 2);
        irq_ack = 1; step(); irq_ack = 0; step();
        chk(cap_flag == 1'b0, "R8 ack clear", int'(cap_flag), 0);

        // R8 set wins over clear
        edge_rise = 1; cap_pin = 1; step(); step();
        flag_clr = 1; step(); flag_clr = 0;
        chk(cap_flag == 1'b1, "R8 set beats clear", int'(cap_flag), 1);

        // R9 gating
        glob_ie = 0; step();
        chk(irq == 1'b0, "R9 global off", int'(irq), 0);
        glob_ie = 1; int_en = 0; step();
        chk(irq == 1'b0, "R9 enable off", int'(irq), 0);
        int_en = 1; step();
        chk(irq == 1'b1, "R9 both on", int'(irq), 1);
        flag_clr = 1; step(); flag_clr = 0; step();

        // R3 filter
        filt_en = 1; edge_rise = 0; repeat (4) step();
        cap_pin = 0; repeat (3) step(); cap_pin = 1; repeat (10) step();
        chk(cap_flag == 1'b0, "R3 short glitch rejected", int'(cap_flag), 0);
        c = int'(cnt_val); cap_pin = 0; repeat (9) step();
        chk(cap_val == 16'(c + 6), "R3 filtered latency", int'(cap_val), c + 6);
        chk(cap_flag == 1'b1, "R3 filtered flag", int'(cap_flag), 1);
        flag_clr = 1; step(); flag_clr = 0; filt_en = 0; step();

        // R6 / R7 TOP mode
        cap_is_top = 1; v = cap_val;
        cap_pin = 1; repeat (6) step(); cap_pin = 0; repeat (6) step();
        chk(cap_val == v, "R6 pin ignored cap", int'(cap_val), int'(v));
        chk(cap_flag == 1'b0, "R6 pin ignored flag", int'(cap_flag), 0);
        cnt_at_top = 1; step(); cnt_at_top = 0;
        chk(cap_flag == 1'b1, "R6 top sets flag", int'(cap_flag), 1);
        chk(cap_val == v, "R6 top keeps cap", int'(cap_val), int'(v));
        cap_wr = 1; cap_wdata = 16'h1234; step(); cap_wr = 0;
        chk(cap_val == 16'h1234, "R7 sw write", int'(cap_val), 16'h1234);
        cap_is_top = 0; cap_wr = 1; cap_wdata = 16'hBEEF; step(); cap_wr = 0; step();
        chk(cap_val == 16'h1234, "R7 write ignored", int'(cap_val), 16'h1234);

        // random mix, checked every clock against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 20) cap_pin = ~cap_pin;
            edge_rise  = ($urandom_range(0, 49) == 0) ? ~edge_rise : edge_rise;
            filt_en    = ($urandom_range(0, 99) == 0) ? ~filt_en : filt_en;
            cap_is_top = ($urandom_range(0, 149) == 0) ? ~cap_is_top : cap_is_top;
            cnt_at_top = ($urandom_range(0, 19) == 0);
            flag_clr   = ($urandom_range(0, 9) == 0);
            irq_ack    = ($urandom_range(0, 14) == 0);
            cap_wr     = ($urandom_range(0, 9) == 0);
            cap_wdata  = 16'($urandom);
            int_en     = ($urandom_range(0, 3) != 0);
            glob_ie    = ($urandom_range(0, 3) != 0);
            step();
        end
        done = 1;
        finish_run();
    end
endmodule